// File: doc/BRIEF.md
# Floating-Point Transfer Address Unit

This unit sits between instruction issue and the data memory port for moves between floating-point registers and memory. For each transfer request it forms the effective address, either from a base register plus a sign-extended 16-bit offset or from a base register plus an index register. It then checks that the address is aligned to the size of the transfer. Aligned requests become memory accesses over a valid/ready handshake, with at most one access outstanding. Misaligned requests are refused with an error pulse, and no memory access is made for them.

Transfers are either one word (32 bits) or one doubleword (64 bits). When the datapath is set to 64 bits, a doubleword moves in a single access. When it is set to 32 bits, a doubleword is split into two word accesses. The low word moves first, at the effective address, to or from the even register of the pair. The high word follows at the address plus 4, to or from the odd register. Data is copied through as raw bits. The unit never interprets it as a number, so no transfer can raise a floating-point exception.

Loaded values can only be used starting one slot after their write-back. The unit does not stall a consumer that comes too early. Instead it raises a hazard flag so that surrounding logic can act on it.

Top module: `fpx_xfer_unit`

## Requirements
- R1: With `req_indexed` low, the effective address is `req_base` plus `req_disp` sign-extended to 32 bits (for example, 0x1020 with offset 0xFFF0 gives 0x1010).
- R2: With `req_indexed` high, the effective address is `req_base + req_index`, and `req_disp` has no effect.
- R3: A word request needs address bits [1:0] equal to 0, and a doubleword request needs bits [2:0] equal to 0. A misaligned request is accepted with `addr_err` high in its acceptance cycle, and it produces no memory access and no write-back.
- R4: `req_ready` is high only when the unit is idle. No new memory access is issued while a load's read data is outstanding.
- R5: With `dp64` high, a doubleword is a single access with `mem_dw`=1 at the effective address. All 64 data bits pass unchanged in both directions, and the write-back register is `req_freg`.
- R6: With `dp64` low, a doubleword becomes two accesses with `mem_dw`=0. The first is at the effective address, carries bits [31:0] and uses register `{req_freg[4:1],0}`. The second is at the address plus 4, carries bits [63:32] and uses `{req_freg[4:1],1}`.
- R7: A word transfer uses `mem_dw`=0. A store drives `{32'h0, req_wdata[31:0]}`, and a load writes back `{32'h0, mem_rdata[31:0]}`. Any bit pattern, including NaN encodings, is copied unchanged.
- R8: `use_hazard` is high exactly in the cycle right after a load's final write-back, when `use_valid` is high and `use_reg` matches the loaded register. For a split doubleword, either register of the pair matches. The flag never lowers `req_ready`.
- R9: Stores produce no write-back.
- R10: After reset, `req_ready` is 1 and `mem_valid`, `wb_valid` and `use_hazard` are 0.
- R11: Once `mem_valid` is raised, it stays high with `mem_addr` and `mem_wdata` held steady until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dp64 | input | 1 | Datapath is 64 bits wide (sampled at acceptance) |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_dbl | input | 1 | 1 = doubleword, 0 = word |
| req_indexed | input | 1 | 1 = base plus index, 0 = base plus offset |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_disp | input | 16 | Signed offset |
| req_freg | input | 5 | FP register number |
| req_wdata | input | 64 | Store data |
| addr_err | output | 1 | Misaligned request refused |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_addr | output | 32 | Access byte address |
| mem_we | output | 1 | Access is a write |
| mem_dw | output | 1 | Access is 64 bits |
| mem_wdata | output | 64 | Write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Read data |
| wb_valid | output | 1 | Register write-back |
| wb_reg | output | 5 | Write-back register |
| wb_data | output | 64 | Write-back data |
| use_valid | input | 1 | Next instruction reads an FP register |
| use_reg | input | 5 | That source register |
| use_hazard | output | 1 | Source reads a just-loaded register too early |

## Verification
The assertions assume a well-behaved memory side. `mem_rvalid` arrives only while a load is waiting for data, and only once per accepted read. `mem_ready` may stall for any number of cycles. The bench's memory responder keeps to these rules: it answers each accepted read exactly once, after a delay of zero or one idle cycles. It also varies `mem_ready` in a fixed pattern, so that request holding is exercised. Request fields are held steady while `req_valid` waits for `req_ready`.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 64;
    localparam int WORD_W   = DATA_W / 2;
    localparam int REG_W    = 5;
    localparam int DISP_W   = 16;
    localparam int WORD_B   = WORD_W / 8;
    localparam int WORD_LSB = $clog2(WORD_B);
    localparam int DBL_LSB  = $clog2(DATA_W / 8);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic              store;
        logic              dbl;
        logic              split;
        logic [REG_W-1:0]  freg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } xfer_ctx_t;

    function automatic logic [ADDR_W-1:0] calc_ea(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] index,
        input logic [DISP_W-1:0] disp,
        input logic              indexed
    );
        logic [ADDR_W-1:0] sext;
        sext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        return indexed ? (base + index) : (base + sext);
    endfunction

    function automatic logic is_misaligned(
        input logic [ADDR_W-1:0] addr,
        input logic              dbl
    );
        logic [ADDR_W-1:0] wmask;
        logic [ADDR_W-1:0] dmask;
        wmask = ADDR_W'((1 << WORD_LSB) - 1);
        dmask = ADDR_W'((1 << DBL_LSB) - 1);
        return dbl ? ((addr & dmask) != '0) : ((addr & wmask) != '0);
    endfunction
endpackage

// File: rtl/fpx_agu.sv
module fpx_agu
    import fpx_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic [DISP_W-1:0] disp,
    input  logic              indexed,
    input  logic              dbl,
    output logic [ADDR_W-1:0] ea,
    output logic              misal
);
    always_comb begin
        ea    = calc_ea(base, index, disp, indexed);
        misal = is_misaligned(ea, dbl);
    end
endmodule

// File: rtl/fpx_seq.sv
module fpx_seq
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  xfer_ctx_t         new_ctx,
    input  logic              misal,
    output logic              addr_err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_dw,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_valid,
    output logic [REG_W-1:0]  wb_reg,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_pair,
    output logic              load_done
);
    xfer_state_e st_q, st_d;
    xfer_ctx_t   ctx_q, ctx_d;
    logic        beat_q, beat_d;
    logic        accept;
    logic        first_half;

    assign req_ready  = (st_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign addr_err   = accept && misal;
    assign first_half = ctx_q.split && !beat_q;

    always_comb begin
        st_d   = st_q;
        ctx_d  = ctx_q;
        beat_d = beat_q;
        case (st_q)
            ST_IDLE: begin
                if (accept && !misal) begin
                    ctx_d  = new_ctx;
                    beat_d = 1'b0;
                    st_d   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mem_ready) begin
                    if (!ctx_q.store)    st_d   = ST_WAIT;
                    else if (first_half) beat_d = 1'b1;
                    else                 st_d   = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    if (first_half) begin
                        beat_d = 1'b1;
                        st_d   = ST_ISSUE;
                    end else begin
                        st_d   = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ctx_q  <= '0;
            beat_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ctx_q  <= ctx_d;
            beat_q <= beat_d;
        end
    end

    always_comb begin
        mem_valid = (st_q == ST_ISSUE);
        mem_we    = ctx_q.store;
        mem_dw    = ctx_q.dbl && !ctx_q.split;
        mem_addr  = ctx_q.addr + (beat_q ? ADDR_W'(WORD_B) : '0);
        if (mem_dw)
            mem_wdata = ctx_q.data;
        else if (beat_q)
            mem_wdata = {{WORD_W{1'b0}}, ctx_q.data[DATA_W-1:WORD_W]};
        else
            mem_wdata = {{WORD_W{1'b0}}, ctx_q.data[WORD_W-1:0]};
    end

    always_comb begin
        wb_valid  = (st_q == ST_WAIT) && mem_rvalid;
        wb_pair   = ctx_q.split;
        wb_reg    = ctx_q.split ? {ctx_q.freg[REG_W-1:1], beat_q} : ctx_q.freg;
        wb_data   = mem_dw ? mem_rdata : {{WORD_W{1'b0}}, mem_rdata[WORD_W-1:0]};
        load_done = wb_valid && !first_half;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata))); // R11
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !mem_we) |=> !mem_valid); // R4
    AST_ERR_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        addr_err |=> !mem_valid); // R3
    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_we) |=> !wb_valid); // R9
    AST_EVEN_FIRST: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !load_done) |-> !wb_reg[0]); // R6
endmodule

// File: rtl/fpx_hazard.sv
module fpx_hazard
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_done,
    input  logic [REG_W-1:0] ld_reg,
    input  logic             ld_pair,
    input  logic             use_valid,
    input  logic [REG_W-1:0] use_reg,
    output logic             use_hazard
);
    logic             last_vld_q;
    logic [REG_W-1:0] last_reg_q;
    logic             last_pair_q;
    logic             match;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_vld_q  <= 1'b0;
            last_reg_q  <= '0;
            last_pair_q <= 1'b0;
        end else begin
            last_vld_q <= load_done;
            if (load_done) begin
                last_reg_q  <= ld_reg;
                last_pair_q <= ld_pair;
            end
        end
    end

    assign match      = last_pair_q ? (use_reg[REG_W-1:1] == last_reg_q[REG_W-1:1])
                                    : (use_reg == last_reg_q);
    assign use_hazard = use_valid && last_vld_q && match;

    AST_HZ_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        use_hazard |-> $past(load_done)); // R8
endmodule

// File: rtl/fpx_xfer_unit.sv
module fpx_xfer_unit
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dp64,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic              req_dbl,
    input  logic              req_indexed,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_index,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [REG_W-1:0]  req_freg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              addr_err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_dw,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_valid,
    output logic [REG_W-1:0]  wb_reg,
    output logic [DATA_W-1:0] wb_data,
    input  logic              use_valid,
    input  logic [REG_W-1:0]  use_reg,
    output logic              use_hazard
);
    logic [ADDR_W-1:0] ea;
    logic              misal;
    xfer_ctx_t         new_ctx;
    logic              wb_pair;
    logic              load_done;

    fpx_agu agu_i (
        .base    (req_base),
        .index   (req_index),
        .disp    (req_disp),
        .indexed (req_indexed),
        .dbl     (req_dbl),
        .ea      (ea),
        .misal   (misal)
    );

    always_comb begin
        new_ctx.store = req_store;
        new_ctx.dbl   = req_dbl;
        new_ctx.split = req_dbl && !dp64;
        new_ctx.freg  = req_freg;
        new_ctx.addr  = ea;
        new_ctx.data  = req_wdata;
    end

    fpx_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .new_ctx    (new_ctx),
        .misal      (misal),
        .addr_err   (addr_err),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_dw     (mem_dw),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .wb_valid   (wb_valid),
        .wb_reg     (wb_reg),
        .wb_data    (wb_data),
        .wb_pair    (wb_pair),
        .load_done  (load_done)
    );

    fpx_hazard hz_i (
        .clk        (clk),
        .rst        (rst),
        .load_done  (load_done),
        .ld_reg     (wb_reg),
        .ld_pair    (wb_pair),
        .use_valid  (use_valid),
        .use_reg    (use_reg),
        .use_hazard (use_hazard)
    );

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_dw ? (mem_addr[2:0] == 3'b000) : (mem_addr[1:0] == 2'b00))); // R3
endmodule

// File: tb/fpx_xfer_unit_tb.sv
module fpx_xfer_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        dp64, req_valid, req_ready, req_store, req_dbl, req_indexed;
    logic [31:0] req_base, req_index;
    logic [15:0] req_disp;
    logic [4:0]  req_freg;
    logic [63:0] req_wdata;
    logic        addr_err, mem_valid, mem_ready, mem_we, mem_dw, mem_rvalid;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic        wb_valid, use_valid, use_hazard;
    logic [4:0]  wb_reg, use_reg;
    logic [63:0] wb_data;

    always #5 clk = ~clk;

    fpx_xfer_unit dut_i (
        .clk(clk), .rst(rst), .dp64(dp64),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_dbl(req_dbl), .req_indexed(req_indexed), .req_base(req_base),
        .req_index(req_index), .req_disp(req_disp), .req_freg(req_freg),
        .req_wdata(req_wdata), .addr_err(addr_err),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_dw(mem_dw), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
        .use_valid(use_valid), .use_reg(use_reg), .use_hazard(use_hazard)
    );

    typedef struct {
        bit st; bit dbl; bit idx; bit wide;
        logic [31:0] base; logic [31:0] index; logic [15:0] disp;
        logic [4:0] freg; logic [63:0] data; string tag;
    } req_t;

    typedef struct {
        logic [31:0] addr; bit we; bit dw; logic [63:0] wdata;
        logic [4:0] wreg; bit last; bit pair; string tag;
    } acc_t;

    req_t        req_q[$];
    acc_t        acc_q[$];
    acc_t        wb_q[$];
    logic [31:0] mem_m [logic [31:0]];

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    bit          rsp_pend = 0;
    int          rsp_dly  = 0;
    acc_t        rsp_acc;
    bit          hz_vld = 0;
    logic [4:0]  hz_reg = '0;
    bit          hz_pair = 0;
    logic [4:0]  tgt = 5'd1;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;
    logic [63:0] prev_wdata = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem_m.exists(a) ? mem_m[a] : (a ^ 32'h5A5A_0F0F);
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic add(input bit st, input bit dbl, input bit idx, input bit wide,
                       input logic [31:0] base, input logic [31:0] index, input logic [15:0] disp,
                       input logic [4:0] freg, input logic [63:0] data, input string tag);
        req_t r;
        r.st = st; r.dbl = dbl; r.idx = idx; r.wide = wide; r.base = base; r.index = index;
        r.disp = disp; r.freg = freg; r.data = data; r.tag = tag;
        req_q.push_back(r);
    endtask

    task automatic expand(input req_t r);
        logic [31:0] ea;
        bit          mis;
        acc_t        a;
        ea  = r.idx ? r.base + r.index : r.base + {{16{r.disp[15]}}, r.disp};
        mis = r.dbl ? (ea[2:0] != 0) : (ea[1:0] != 0);
        chk(mis ? "R3" : r.tag, "addr_err", {63'd0, addr_err}, {63'd0, mis});
        if (mis) return;
        tgt = r.freg;
        a.we = r.st; a.tag = r.tag;
        if (r.dbl && !r.wide) begin
            a.addr = ea; a.dw = 0; a.wdata = {32'h0, r.data[31:0]};
            a.wreg = {r.freg[4:1], 1'b0}; a.last = 0; a.pair = 1;
            acc_q.push_back(a);
            a.addr = ea + 4; a.wdata = {32'h0, r.data[63:32]};
            a.wreg = {r.freg[4:1], 1'b1}; a.last = 1;
            acc_q.push_back(a);
        end else begin
            a.addr = ea; a.dw = r.dbl; a.wreg = r.freg; a.last = 1; a.pair = 0;
            a.wdata = r.dbl ? r.data : {32'h0, r.data[31:0]};
            acc_q.push_back(a);
        end
    endtask

    task automatic step();
        bit         hz_exp;
        bit         nxt_vld;
        acc_t       a;
        @(negedge clk);
        cyc++;
        if (req_q.size() > 0) begin
            req_valid = 1; req_store = req_q[0].st; req_dbl = req_q[0].dbl;
            req_indexed = req_q[0].idx; dp64 = req_q[0].wide; req_base = req_q[0].base;
            req_index = req_q[0].index; req_disp = req_q[0].disp; req_freg = req_q[0].freg;
            req_wdata = req_q[0].data;
        end else begin
            req_valid = 0;
        end
        mem_ready  = (cyc % 4 != 1);
        mem_rvalid = 0;
        mem_rdata  = 64'hBAD0_BAD0_BAD0_BAD0;
        if (rsp_pend) begin
            if (rsp_dly == 0) begin
                mem_rvalid = 1;
                mem_rdata  = rsp_acc.dw ? {rd(rsp_acc.addr + 4), rd(rsp_acc.addr)}
                                        : {~rd(rsp_acc.addr), rd(rsp_acc.addr)};
                rsp_pend = 0;
            end else begin
                rsp_dly--;
            end
        end
        use_valid = (cyc % 5 != 4);
        use_reg   = (cyc % 3 == 0) ? 5'd0 : ((cyc % 3 == 1) ? tgt : (tgt ^ 5'd1));
        #1;
        hz_exp = use_valid && hz_vld &&
                 (hz_pair ? (use_reg[4:1] == hz_reg[4:1]) : (use_reg == hz_reg));
        chk("R8", "use_hazard", {63'd0, use_hazard}, {63'd0, hz_exp});
        if (prev_stall) begin
            chk("R11", "mem_valid held", {63'd0, mem_valid}, 64'd1);
            chk("R11", "mem_addr held", {32'd0, mem_addr}, {32'd0, prev_addr});
            chk("R11", "mem_wdata held", mem_wdata, prev_wdata);
        end
        if (req_valid && req_ready) begin
            expand(req_q.pop_front());
        end else if (addr_err) begin
            chk("R3", "addr_err without request", 64'd1, 64'd0);
        end
        if (mem_valid && mem_ready) begin
            if (acc_q.size() == 0 || wb_q.size() != 0 || rsp_pend) begin
                chk("R4", "unexpected access", {32'd0, mem_addr}, 64'd0);
            end else begin
                a = acc_q.pop_front();
                chk(a.tag, "mem_addr", {32'd0, mem_addr}, {32'd0, a.addr});
                chk(a.tag, "mem_we", {63'd0, mem_we}, {63'd0, a.we});
                chk(a.tag, "mem_dw", {63'd0, mem_dw}, {63'd0, a.dw});
                if (a.we) begin
                    chk(a.tag, "mem_wdata", mem_wdata, a.wdata);
                    mem_m[a.addr] = a.wdata[31:0];
                    if (a.dw) mem_m[a.addr + 4] = a.wdata[63:32];
                end else begin
                    rsp_pend = 1; rsp_dly = cyc % 2; rsp_acc = a;
                    wb_q.push_back(a);
                end
            end
        end
        nxt_vld = 0;
        if (wb_valid) begin
            if (wb_q.size() == 0) begin
                chk("R9", "unexpected write-back", {59'd0, wb_reg}, 64'd0);
            end else begin
                a = wb_q.pop_front();
                chk(a.tag, "wb_reg", {59'd0, wb_reg}, {59'd0, a.wreg});
                chk(a.tag, "wb_data", wb_data,
                    a.dw ? {rd(a.addr + 4), rd(a.addr)} : {32'h0, rd(a.addr)});
                if (a.last) begin
                    nxt_vld = 1; hz_reg = a.wreg; hz_pair = a.pair;
                end
            end
        end
        hz_vld     = nxt_vld;
        prev_stall = mem_valid && !mem_ready;
        prev_addr  = mem_addr;
        prev_wdata = mem_wdata;
    endtask

    initial begin
        bit done;
        rst = 1; req_valid = 0; dp64 = 0; req_store = 0; req_dbl = 0; req_indexed = 0;
        req_base = '0; req_index = '0; req_disp = '0; req_freg = '0; req_wdata = '0;
        mem_ready = 0; mem_rvalid = 0; mem_rdata = '0; use_valid = 0; use_reg = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R10 reset state
        chk("R10", "req_ready", {63'd0, req_ready}, 64'd1);
        chk("R10", "mem_valid", {63'd0, mem_valid}, 64'd0);
        chk("R10", "wb_valid", {63'd0, wb_valid}, 64'd0);
        chk("R10", "use_hazard", {63'd0, use_hazard}, 64'd0);

        add(1, 0, 0, 0, 32'h1000, 32'h0,  16'h0010, 5'd2,  64'hFFFF_FFFF_7FC0_0001, "R7");
        add(0, 0, 1, 0, 32'h1008, 32'h8,  16'h7777, 5'd3,  64'h0, "R2");
        add(0, 0, 0, 0, 32'h1020, 32'h0,  16'hFFF0, 5'd4,  64'h0, "R1");
        add(0, 0, 0, 0, 32'h1002, 32'h0,  16'h0000, 5'd5,  64'h0, "R3");
        add(1, 1, 0, 0, 32'h1004, 32'h0,  16'h0000, 5'd6,  64'h1, "R3");
        add(1, 1, 0, 0, 32'h2000, 32'h0,  16'h0008, 5'd7,  64'h0123_4567_89AB_CDEF, "R6");
        add(0, 1, 0, 0, 32'h2000, 32'h0,  16'h0008, 5'd9,  64'h0, "R6");
        add(1, 1, 1, 1, 32'h3000, 32'h18, 16'h0004, 5'd3,  64'hFFF8_0000_0000_0000, "R5");
        add(0, 1, 1, 1, 32'h3000, 32'h18, 16'h0000, 5'd4,  64'h0, "R5");
        add(0, 0, 0, 1, 32'h4000, 32'h0,  16'h0004, 5'd10, 64'h0, "R7");
        add(0, 1, 1, 1, 32'h5000, 32'h2,  16'h0000, 5'd11, 64'h0, "R3");
        add(0, 1, 0, 0, 32'h2000, 32'h0,  16'h0000, 5'd5,  64'h0, "R6");
        add(1, 0, 1, 1, 32'h6000, 32'h4,  16'h8000, 5'd12, 64'h1234_5678_7F80_0000, "R2");
        add(0, 0, 0, 0, 32'h6010, 32'h0,  16'hFFF4, 5'd12, 64'h0, "R1");

        done = 0;
        for (int i = 0; i < 5000 && !done; i++) begin
            step();
            done = (req_q.size() == 0) && (acc_q.size() == 0) && (wb_q.size() == 0) && !rsp_pend;
        end
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog act=hung exp=complete");
        end else begin
            repeat (4) step();
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule